// File: doc/BRIEF.md
# eFuse read access sequencer

This block reads bytes out of a one-time-programmable fuse macro. A host gives it a 10-bit start address and a byte count, then pulses `start_i`. The block walks the macro through a timed load/strobe handshake, one byte per address. Every step is held for one microsecond. The length of that gap is worked out from the clock frequency parameter.

Each byte the macro returns is shown for one cycle on `rd_vld_o`. The byte comes with the address it was read from. When the last byte is done, the macro goes back to its standby encoding and `done_o` pulses. Programming stays disabled the whole time. A write request is acknowledged and has no effect. All macro pins are carried in one 16-bit control word, whose bit positions the macro decodes.

Top module: `efuse_rd_seq`

## Requirements
- R1: While and after reset, `fuse_ctrl_o` holds the standby word 16'h0009, and `busy_o`, `done_o`, `rd_vld_o` and `wr_ack_o` are low.
- R2: In `fuse_ctrl_o`, bit 0 is chip-select (active low), bit 1 is strobe, bit 2 is load and bit 3 is program-disable. Bits 15:6 carry the fuse address. Bits 5:4 are zero.
- R3: A run opens in the cycle after `start_i` is sampled. The word is 16'h000C (load and program-disable high, chip-select and strobe low, address 0). It is held for GAP cycles, where GAP = ceil(CLK_FREQ_HZ / 1e6).
- R4: Each byte has three phases of GAP cycles each:
  - address: word 16'h000C with the address in bits 15:6;
  - strobe: the same word with bit 1 set;
  - release: strobe low, address held.
- R5: The macro data is sampled on the last clock edge of the strobe phase. In the first cycle of the release phase, `rd_vld_o` is high for exactly one cycle, with the byte on `rd_data_o` and its address on `rd_addr_o`.
- R6: The address rises by one per byte and wraps from 1023 to 0.
- R7: In the cycle after the last release phase:
  - `fuse_ctrl_o` returns to 16'h0009;
  - `busy_o` falls;
  - `done_o` is high for exactly one cycle.
- R8: A byte count of zero opens the session for GAP cycles, then enters standby with a `done_o` pulse and no `rd_vld_o`.
- R9: Program-disable (bit 3) is never low. A write request on `wr_req_i` is answered by `wr_ack_o` one cycle later and leaves `fuse_ctrl_o` and the read outputs unchanged.
- R10: A `start_i` sampled while `busy_o` is high is ignored. The running sequence and its addresses carry on unchanged.
- R11: `busy_o` is high from the cycle after an accepted start through the last release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a read run (sampled when idle) |
| start_addr_i | input | 10 | First fuse address |
| byte_cnt_i | input | CNT_W | Number of bytes to read |
| wr_req_i | input | 1 | Write request (no effect) |
| wr_ack_o | output | 1 | Write acknowledge, one cycle after request |
| fuse_ctrl_o | output | 16 | Macro control word: pins and address |
| fuse_dout_i | input | 8 | Macro data output |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse on return to standby |
| rd_vld_o | output | 1 | Byte valid pulse |
| rd_data_o | output | 8 | Captured byte |
| rd_addr_o | output | 10 | Address of the captured byte |

## Verification
The assertions take for granted two things about the inputs:
- reset is applied before the first start;
- `start_addr_i` and `byte_cnt_i` are stable in the cycle `start_i` is sampled.

They assume nothing about `fuse_dout_i` or about when `start_i` and `wr_req_i` arrive. The stimulus changes inputs only on the falling clock edge and holds address and count with the start pulse. It then fires extra start pulses and write requests in the middle of runs, which is where the protocol properties are most exposed.

// File: rtl/efuse_rd_pkg.sv
package efuse_rd_pkg;
  localparam int CTRL_W   = 16;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 8;
  localparam int CSB_BIT  = 0;
  localparam int STRB_BIT = 1;
  localparam int LOAD_BIT = 2;
  localparam int PGENB_BIT = 3;
  localparam int ADDR_LSB = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_ADDR,
    ST_STRB,
    ST_REL
  } seq_st_e;
endpackage

// File: rtl/efuse_gap_timer.sv
module efuse_gap_timer #(
  parameter int GAP = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  localparam int TW = (GAP > 1) ? $clog2(GAP) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= TW'(GAP - 1);
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/efuse_ctrl_pack.sv
module efuse_ctrl_pack
  import efuse_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_st_e           st_nxt_i,
  input  logic [ADDR_W-1:0] addr_nxt_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] word_d;

  always_comb begin
    word_d = '0;
    word_d[PGENB_BIT] = 1'b1;  // programming always disabled
    unique case (st_nxt_i)
      ST_IDLE: word_d[CSB_BIT] = 1'b1;
      ST_OPEN: word_d[LOAD_BIT] = 1'b1;
      ST_ADDR, ST_REL: begin
        word_d[LOAD_BIT] = 1'b1;
        word_d[ADDR_LSB +: ADDR_W] = addr_nxt_i;
      end
      ST_STRB: begin
        word_d[LOAD_BIT] = 1'b1;
        word_d[STRB_BIT] = 1'b1;
        word_d[ADDR_LSB +: ADDR_W] = addr_nxt_i;
      end
      default: word_d[CSB_BIT] = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= CTRL_W'((1 << PGENB_BIT) | (1 << CSB_BIT));
    else         ctrl_o <= word_d;
  end
endmodule

// File: rtl/efuse_rd_seq.sv
module efuse_rd_seq
  import efuse_rd_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int CNT_W       = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [9:0]        start_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              wr_req_i,
  output logic              wr_ack_o,
  output logic [15:0]       fuse_ctrl_o,
  input  logic [7:0]        fuse_dout_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_vld_o,
  output logic [7:0]        rd_data_o,
  output logic [9:0]        rd_addr_o
);
  localparam int GAP = (CLK_FREQ_HZ + 999_999) / 1_000_000;
  localparam int GAP_EFF = (GAP < 1) ? 1 : GAP;

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              expire, tmr_load;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    left_d = left_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_OPEN;
        addr_d = start_addr_i;
        left_d = byte_cnt_i;
      end
      ST_OPEN: if (expire) st_d = (left_q == '0) ? ST_IDLE : ST_ADDR;
      ST_ADDR: if (expire) st_d = ST_STRB;
      ST_STRB: if (expire) st_d = ST_REL;
      ST_REL:  if (expire) begin
        left_d = left_q - 1'b1;
        if (left_q == CNT_W'(1)) st_d = ST_IDLE;
        else begin
          st_d   = ST_ADDR;
          addr_d = addr_q + 1'b1;  // wraps modulo 1024
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (st_d != st_q) && (st_d != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      left_q    <= '0;
      done_o    <= 1'b0;
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
      rd_addr_o <= '0;
      wr_ack_o  <= 1'b0;
    end else begin
      st_q     <= st_d;
      addr_q   <= addr_d;
      left_q   <= left_d;
      done_o   <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
      rd_vld_o <= (st_q == ST_STRB) && expire;
      if ((st_q == ST_STRB) && expire) begin
        rd_data_o <= fuse_dout_i;
        rd_addr_o <= addr_q;
      end
      wr_ack_o <= wr_req_i;  // read-only: accept and drop
    end
  end

  assign busy_o = (st_q != ST_IDLE);

  efuse_gap_timer #(.GAP(GAP_EFF)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .expire_o (expire)
  );

  efuse_ctrl_pack u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_nxt_i   (st_d),
    .addr_nxt_i (addr_d),
    .ctrl_o     (fuse_ctrl_o)
  );
endmodule

// File: rtl/efuse_rd_seq_chk.sv
module efuse_rd_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] fuse_ctrl_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        rd_vld_o,
  input logic        wr_req_i,
  input logic        wr_ack_o
);
  a_r9_pgenb_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_ctrl_o[3]);

  a_r4_strobe_in_session: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_ctrl_o[1] |-> (fuse_ctrl_o[2] && !fuse_ctrl_o[0] && busy_o));

  a_r4_addr_stable_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_ctrl_o[1] && $past(fuse_ctrl_o[1])) |-> $stable(fuse_ctrl_o[15:6]));

  a_r5_vld_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> ($past(fuse_ctrl_o[1]) && !fuse_ctrl_o[1]));

  a_r5_vld_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |=> !rd_vld_o);

  a_r7_done_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fuse_ctrl_o == 16'h0009 && !busy_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_busy_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  a_r9_wr_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> wr_ack_o);
endmodule

bind efuse_rd_seq efuse_rd_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fuse_ctrl_o (fuse_ctrl_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rd_vld_o    (rd_vld_o),
  .wr_req_i    (wr_req_i),
  .wr_ack_o    (wr_ack_o)
);

// File: tb/sim_efuse_rd_seq.sv
module sim_efuse_rd_seq;
  localparam int FREQ = 50_000_000;
  localparam int GAP  = (FREQ + 999_999) / 1_000_000;
  localparam int CW   = 11;

  typedef struct {
    logic [15:0] ctrl;
    bit          busy;
    bit          done;
    bit          vld;
    logic [7:0]  data;
    logic [9:0]  raddr;
    string       tag;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [9:0]    start_addr_i = '0;
  logic [CW-1:0] byte_cnt_i = '0;
  logic          wr_req_i = 1'b0;
  logic          wr_ack_o;
  logic [15:0]   fuse_ctrl_o;
  logic [7:0]    fuse_dout_i;
  logic          busy_o, done_o, rd_vld_o;
  logic [7:0]    rd_data_o;
  logic [9:0]    rd_addr_o;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t q[$];
  bit   exp_ack = 1'b0;

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] fuse_val(int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  // behavioural fuse array: data only while strobed and selected
  assign fuse_dout_i = (fuse_ctrl_o[1] && fuse_ctrl_o[2] && !fuse_ctrl_o[0])
                       ? fuse_val(int'(fuse_ctrl_o[15:6])) : 8'h00;

  efuse_rd_seq #(.CLK_FREQ_HZ(FREQ), .CNT_W(CW)) u0 (
    .clk_i, .rst_ni, .start_i, .start_addr_i, .byte_cnt_i,
    .wr_req_i, .wr_ack_o, .fuse_ctrl_o, .fuse_dout_i,
    .busy_o, .done_o, .rd_vld_o, .rd_data_o, .rd_addr_o
  );

  function automatic exp_t mk(logic [15:0] c, bit b, string t);
    exp_t e;
    e.ctrl = c; e.busy = b; e.done = 1'b0; e.vld = 1'b0;
    e.data = '0; e.raddr = '0; e.tag = t;
    return e;
  endfunction

  task automatic build(int a, int n);
    exp_t e;
    for (int i = 0; i < GAP; i++) q.push_back(mk(16'h000C, 1'b1, "R3"));
    for (int b = 0; b < n; b++) begin
      int ad = (a + b) % 1024;
      logic [15:0] w = 16'h000C | 16'(ad << 6);
      for (int i = 0; i < GAP; i++) q.push_back(mk(w, 1'b1, "R4"));
      for (int i = 0; i < GAP; i++) q.push_back(mk(w | 16'h0002, 1'b1, "R4"));
      for (int i = 0; i < GAP; i++) begin
        e = mk(w, 1'b1, (i == 0) ? "R5" : "R6");
        if (i == 0) begin
          e.vld = 1'b1; e.data = fuse_val(ad); e.raddr = 10'(ad);
        end
        q.push_back(e);
      end
    end
    e = mk(16'h0009, 1'b0, (n == 0) ? "R8" : "R7");
    e.done = 1'b1;
    q.push_back(e);
  endtask

  // reference model: accepts start only when its own timeline is empty (R10)
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      q.delete();
      exp_ack <= 1'b0;
    end else begin
      exp_ack <= wr_req_i;
      if (start_i && q.size() == 0) build(int'(start_addr_i), int'(byte_cnt_i));
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      exp_t e;
      if (q.size() != 0) e = q.pop_front();
      else e = mk(16'h0009, 1'b0, "R11");
      chk(fuse_ctrl_o === e.ctrl, e.tag, "ctrl", int'(fuse_ctrl_o), int'(e.ctrl));
      chk(busy_o === e.busy, "R11", "busy", int'(busy_o), int'(e.busy));
      chk(done_o === e.done, "R7", "done", int'(done_o), int'(e.done));
      chk(rd_vld_o === e.vld, "R5", "vld", int'(rd_vld_o), int'(e.vld));
      if (e.vld) begin
        chk(rd_data_o === e.data, "R5", "data", int'(rd_data_o), int'(e.data));
        chk(rd_addr_o === e.raddr, "R6", "addr", int'(rd_addr_o), int'(e.raddr));
      end
      chk(fuse_ctrl_o[3] === 1'b1, "R9", "pgenb", int'(fuse_ctrl_o[3]), 1);
      chk(wr_ack_o === exp_ack, "R9", "wr_ack", int'(wr_ack_o), int'(exp_ack));
    end
  end

  task automatic go(int a, int n);
    @(negedge clk_i);
    start_i = 1'b1; start_addr_i = 10'(a); byte_cnt_i = CW'(n);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (q.size() != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(fuse_ctrl_o === 16'h0009, "R1", "rst ctrl", int'(fuse_ctrl_o), 'h9);
    chk(busy_o === 1'b0 && done_o === 1'b0 && rd_vld_o === 1'b0 && wr_ack_o === 1'b0,
        "R1", "rst flags", int'({busy_o, done_o, rd_vld_o, wr_ack_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 R3 R4 R5: plain run
    go(5, 3);
    wait_idle();

    // R6 R10 R9: wrap run with stray start and writes mid-run
    go(1022, 4);
    repeat (GAP * 2) @(negedge clk_i);
    start_i = 1'b1; start_addr_i = 10'd100; byte_cnt_i = CW'(9);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (GAP + 7) @(negedge clk_i);
    wr_req_i = 1'b1;
    repeat (2) @(negedge clk_i);
    wr_req_i = 1'b0;
    wait_idle();

    // R8: zero count
    go(300, 0);
    wait_idle();

    // R9: write while idle
    wr_req_i = 1'b1;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    repeat (2) @(negedge clk_i);

    // R7: single byte at top address, then back-to-back start
    go(1023, 1);
    while (q.size() > 1) @(negedge clk_i);
    start_i = 1'b1; start_addr_i = 10'd512; byte_cnt_i = CW'(2);
    @(negedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    wait_idle();

    finish_run();
  end

  initial begin
    repeat (100_000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule